// File: doc/BRIEF.md
# Reversible Decimal Digit Counter

This block counts one decimal digit, held in 8421 code, up or down on the rising clock edge. A low level on the load input presets the digit from four data inputs at once, without waiting for a clock edge. The load takes priority over both counting and holding. When counting is not enabled, the digit holds its value.

Two outputs let several digits be cascaded. A terminal-count flag marks the last digit in the current direction. An active-low ripple-clock pulse appears during the low phase of the clock when that last digit is reached with counting enabled. A higher stage can use this pulse as its carry or borrow. Codes above nine can only be reached through a load. In either direction, the counter steps out of them along a fixed path.

Top module: `dec_rev_counter`

## Requirements
- R1: While `rst_n` is low, the digit `q` is 0 immediately, with no clock edge needed.
- R2: While `load_n` is low, `q` equals `din` without any clock edge. After `load_n` returns high, `q` keeps that value.
- R3: With `load_n` high and `cnt_en_n` high, `q` does not change on clock edges.
- R4: With `load_n` high, `cnt_en_n` low and `dir_down` low, each rising edge moves `q` up by one through 0..9, and 9 is followed by 0.
- R5: With `load_n` high, `cnt_en_n` low and `dir_down` high, each rising edge moves `q` down by one through 9..0, and 0 is followed by 9.
- R6: Counting up from an out-of-range code gives these next values: 10→11, 11→4, 12→13, 13→2, 14→15, 15→0.
- R7: Counting down from an out-of-range code (10..15) gives that code minus one.
- R8: `term` is high exactly when `q`=9 with `dir_down` low, or when `q`=0 with `dir_down` high. It follows `dir_down` at once, does not depend on `cnt_en_n`, and is never high for codes 10..15.
- R9: `ripple_n` is low only while `load_n` is high, `cnt_en_n` is low, `term` is high and `clk` is low. At all other times it is high, including throughout the clock-high phase.
- R10: A low `load_n` held across rising edges while counting is enabled keeps `q` equal to `din`. The first edge after release counts from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low clear |
| load_n | input | 1 | Asynchronous active-low preset |
| din | input | 4 | Preset value |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | 0 = count up, 1 = count down |
| q | output | 4 | Current digit |
| term | output | 1 | Terminal-count flag |
| ripple_n | output | 1 | Active-low carry/borrow pulse in the clock-low phase |

## Verification
The preset and the count can both claim the same clock edge. To provoke this, the load is held low across several rising edges while counting is enabled, and `q` must stay at the preset value every time. The preset and the ripple pulse also meet in one low phase. With the digit at its terminal value and counting enabled, the bench lowers the load mid-phase and expects `ripple_n` to rise at once.

// File: rtl/dec_cnt_pkg.sv
package dec_cnt_pkg;
  localparam int DIG_W   = 4;
  localparam int DIG_TOP = 9;
  typedef logic [DIG_W-1:0] digit_t;
endpackage

// File: rtl/dec_cnt_next.sv
module dec_cnt_next
  import dec_cnt_pkg::*;
(
  input  digit_t state_i,
  input  logic   down_i,
  output digit_t next_o
);
  localparam digit_t TOP  = digit_t'(DIG_TOP);
  localparam digit_t ZERO = '0;

  always_comb begin
    if (down_i) begin
      next_o = (state_i == ZERO) ? TOP : state_i - digit_t'(1);
    end else begin
      unique case (state_i)
        TOP:         next_o = ZERO;
        digit_t'(11): next_o = digit_t'(4);
        digit_t'(13): next_o = digit_t'(2);
        digit_t'(15): next_o = ZERO;
        default:     next_o = state_i + digit_t'(1);
      endcase
    end
  end
endmodule

// File: rtl/dec_cnt_tc.sv
module dec_cnt_tc
  import dec_cnt_pkg::*;
(
  input  digit_t value_i,
  input  logic   down_i,
  output logic   tc_o
);
  localparam digit_t TOP = digit_t'(DIG_TOP);

  always_comb begin
    tc_o = down_i ? (value_i == '0) : (value_i == TOP);
  end

  // R8: never flag an out-of-range code
  always_comb begin
    p_tc_legal_r8: assert (!(tc_o && (value_i > TOP)));
  end
endmodule

// File: rtl/dec_cnt_ripple.sv
module dec_cnt_ripple (
  input  logic clk,
  input  logic load_n,
  input  logic en_n,
  input  logic tc_i,
  output logic ripple_n_o
);
  always_comb begin
    ripple_n_o = ~(load_n & ~en_n & tc_i & ~clk);
  end
endmodule

// File: rtl/dec_rev_counter.sv
module dec_rev_counter
  import dec_cnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [DIG_W-1:0] din,
  input  logic             cnt_en_n,
  input  logic             dir_down,
  output logic [DIG_W-1:0] q,
  output logic             term,
  output logic             ripple_n
);
  localparam digit_t TOP = digit_t'(DIG_TOP);

  digit_t state_q;
  digit_t state_d;
  digit_t step_v;

  dec_cnt_next u_next (
    .state_i (state_q),
    .down_i  (dir_down),
    .next_o  (step_v)
  );

  // next-state selection
  always_comb begin
    state_d = state_q;
    if (!cnt_en_n) state_d = step_v;
  end

  // state register: clear and preset are both asynchronous
  always_ff @(posedge clk or negedge rst_n or negedge load_n) begin
    if (!rst_n)       state_q <= '0;
    else if (!load_n) state_q <= din;
    else              state_q <= state_d;
  end

  // preset is visible at once while load is low
  always_comb begin
    q = load_n ? state_q : din;
  end

  dec_cnt_tc u_tc (
    .value_i (q),
    .down_i  (dir_down),
    .tc_o    (term)
  );

  dec_cnt_ripple u_rip (
    .clk        (clk),
    .load_n     (load_n),
    .en_n       (cnt_en_n),
    .tc_i       (term),
    .ripple_n_o (ripple_n)
  );

  // R2: a load held across two edges with steady data has been captured
  p_load_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && $past(!load_n) && $stable(din)) |-> (state_q == din));

  // R3: disabled counter keeps its digit
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || !load_n)
    (load_n && cnt_en_n) |=> $stable(state_q));

  // R4: upward wrap
  p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n || !load_n)
    (!cnt_en_n && !dir_down && state_q == TOP) |=> (state_q == '0));

  // R5: downward wrap
  p_wrap_down_r5: assert property (@(posedge clk) disable iff (!rst_n || !load_n)
    (!cnt_en_n && dir_down && state_q == '0) |=> (state_q == TOP));

  // R9: a ripple pulse needs a flagged terminal count in the clock-low phase
  always_comb begin
    if (rst_n && !ripple_n)
      p_ripple_gate_r9: assert (term && !clk && load_n && !cnt_en_n);
  end
endmodule

// File: tb/dec_rev_counter_test.sv
module dec_rev_counter_test;
  logic       clk = 1'b0;
  logic       rst_n, load_n, cnt_en_n, dir_down;
  logic [3:0] din;
  logic [3:0] q;
  logic       term, ripple_n;
  int total = 0;
  int bad = 0;
  bit done = 0;

  dec_rev_counter uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .cnt_en_n(cnt_en_n), .dir_down(dir_down),
    .q(q), .term(term), .ripple_n(ripple_n)
  );

  always #5 clk = ~clk;

  function automatic int model_next(int v, bit dn);
    if (dn) return (v == 0) ? 9 : v - 1;
    case (v)
      9: return 0;  11: return 4;  13: return 2;  15: return 0;
      default: return v + 1;
    endcase
  endfunction

  function automatic bit model_tc(int v, bit dn);
    return dn ? (v == 0) : (v == 9);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_load(int v);
    tick();
    cnt_en_n = 1'b1; din = 4'(v); load_n = 1'b0;
    #1 chk("R2 immediate", q, v);
    tick();
    load_n = 1'b0;
    #1 load_n = 1'b1;
    #1 chk("R2 retained", q, v);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; load_n = 1'b1; cnt_en_n = 1'b1; dir_down = 1'b0; din = 4'd0;
    #3 chk("R1 clear", q, 0);
    #20 rst_n = 1'b1;
    chk("R1 after release", q, 0);
  endtask

  task automatic t_hold();
    do_load(6);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R3 hold", q, 6);
    end
  endtask

  task automatic t_count(bit dn, int start, int steps, string req);
    int exp;
    do_load(start);
    exp = start;
    tick();
    dir_down = dn; cnt_en_n = 1'b0;
    for (int k = 0; k < steps; k++) begin
      tick();
      exp = model_next(exp, dn);
      chk(req, q, exp);
      chk("R8 flag while counting", term, model_tc(exp, dn));
    end
    cnt_en_n = 1'b1;
  endtask

  task automatic t_illegal();
    for (int v = 10; v < 16; v++) begin
      for (int d = 0; d < 2; d++) begin
        do_load(v);
        dir_down = d[0];
        #1 chk("R8 no flag for illegal", term, 0);
        tick();
        cnt_en_n = 1'b0;
        tick();
        cnt_en_n = 1'b1;
        chk(d ? "R7 down exit" : "R6 up exit", q, model_next(v, d[0]));
      end
    end
  endtask

  task automatic t_tc_dir();
    do_load(9);
    dir_down = 1'b0; #1 chk("R8 nine up", term, 1);
    dir_down = 1'b1; #1 chk("R8 nine down", term, 0);
    do_load(0);
    dir_down = 1'b1; #1 chk("R8 zero down", term, 1);
    dir_down = 1'b0; #1 chk("R8 zero up", term, 0);
  endtask

  task automatic t_ripple();
    do_load(9);
    tick();
    dir_down = 1'b0; cnt_en_n = 1'b0;
    #1 chk("R9 high phase", ripple_n, 1);
    @(negedge clk); #1;
    chk("R9 low phase pulse", ripple_n, 0);
    cnt_en_n = 1'b1;
    #1 chk("R9 disabled", ripple_n, 1);
    chk("R8 flag ignores enable", term, 1);
    cnt_en_n = 1'b0;
    #1 chk("R9 pulse again", ripple_n, 0);
    din = 4'd9; load_n = 1'b0;
    #1 chk("R9 load forces high", ripple_n, 1);
    tick();
    load_n = 1'b1; cnt_en_n = 1'b1;
    #1 chk("R10 load beat count", q, 9);
    do_load(5);
    tick();
    cnt_en_n = 1'b0;
    @(negedge clk); #1;
    chk("R9 no flag no pulse", ripple_n, 1);
    tick();
    cnt_en_n = 1'b1;
  endtask

  task automatic t_load_over_count();
    do_load(2);
    tick();
    dir_down = 1'b0; cnt_en_n = 1'b0; din = 4'd3; load_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R10 preset wins", q, 3);
    end
    load_n = 1'b1;
    tick();
    chk("R10 count after release", q, 4);
    cnt_en_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_hold();
    t_count(1'b0, 4, 8, "R4 up sweep");
    t_count(1'b1, 5, 8, "R5 down sweep");
    t_illegal();
    t_tc_dir();
    t_ripple();
    t_load_over_count();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule